// File: doc/BRIEF.md
# Program and Data Memory Router

This block decodes every access that an 8-bit controller core issues toward memory and picks one destination for it. An access is either an instruction fetch or a data transfer into the auxiliary data space. A fetch may land in the on-chip program ROM or on the external bus. A data transfer may land in a 1 kB on-chip SRAM or on the external bus. The core presents an address, an access kind and a one-cycle strobe. One clock later the router raises exactly one of three destination strobes. For an external fetch it also drives an active-low program-store enable.

The amount of address space served by the on-chip ROM is held in a small size register that software rewrites at run time. A write takes effect for the very next fetch, with no pipeline guard. A pin-level input can force every fetch off-chip whatever the register holds. The on-chip SRAM sits inside the data space as if it were external memory. It claims only the lowest 1 kB, and only while its enable bit is set.

Top module: `mem_router`

## Requirements
- R1: After reset the size register holds code 5 (16 kB), so with no write a fetch at 0x3FFF selects ROM and a fetch at 0x4000 goes external. While reset is held, and in the first cycle after it, all destination strobes are low and `psen_n` is high.
- R2: `size_wdata` is a 3-bit code: 0 means no internal ROM, and codes 1, 2, 3, 4, 5 mean 1, 2, 4, 8, 16 kB. The reserved codes 6 and 7 behave as 16 kB.
- R3: A fetch whose address is below the current internal size raises `rom_sel`. A fetch at or above that size raises `ext_req`.
- R4: While `int_prog_en` is low, every fetch raises `ext_req` and never `rom_sel`, whatever the size code.
- R5: A size write (`size_wr` high) applies to a fetch strobed in the same cycle as the write and to every later fetch.
- R6: `psen_n` is low only in the result cycle of a fetch routed external. It stays high for ROM fetches, for all data accesses and for idle cycles.
- R7: A data access (`acc_is_data` high) with `sram_en` high and address 0x0000 to 0x03FF raises `sram_sel`.
- R8: A data access above 0x03FF, or any data access while `sram_en` is low, raises `ext_req`. The size code and `int_prog_en` have no effect on data accesses.
- R9: The result appears in the cycle after the strobe. Each strobe raises exactly one of `rom_sel`, `sram_sel` and `ext_req` for exactly one cycle. A cycle without a strobe raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_is_data | input | 1 | 1 = data-space transfer, 0 = instruction fetch |
| acc_addr | input | 16 | Access address |
| int_prog_en | input | 1 | Pin level; low forces all fetches external |
| sram_en | input | 1 | Enables the on-chip data SRAM window |
| size_wr | input | 1 | Write strobe for the internal-ROM size register |
| size_wdata | input | 3 | New size code |
| rom_sel | output | 1 | Access routed to on-chip ROM |
| sram_sel | output | 1 | Access routed to on-chip SRAM |
| ext_req | output | 1 | Access routed to the external bus |
| psen_n | output | 1 | Active-low program-store enable for external fetches |

## Verification
Two functions can fall in the same cycle: a software write to the size register and a fetch strobe. The bench issues both on one edge, shrinking the size below the fetch address and then growing it back. It expects the fetch to follow the newly written size in both directions. It also mixes fetches and data transfers back to back while `int_prog_en` and `sram_en` toggle, and judges each result against its own model in the cycle after the strobe.

// File: rtl/mem_route_pkg.sv
// Package: shared route encoding and access-kind type for the memory router.
// Assumes: a 16-bit address space; the route code is used by checkers and benches.
package mem_route_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_ROM  = 2'd1,
        RT_SRAM = 2'd2,
        RT_EXT  = 2'd3
    } route_e;

    typedef enum logic {
        ACC_FETCH = 1'b0,
        ACC_DATA  = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/mr_size_reg.sv
// Module: holds the software-written internal-ROM size code.
// Assumes: a write is a single-cycle strobe; reserved codes are stored as
// written and are interpreted by the decoder.
module mr_size_reg #(
    parameter int SIZE_W   = 3,
    parameter int RST_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SIZE_W-1:0] wdata,
    output logic [SIZE_W-1:0] code
);

    // Capture a new code on a write strobe; reset to the full-size code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= SIZE_W'(RST_CODE);
        else if (wr)
            code <= wdata;
    end

    // R1: the first cycle after reset sees the default size code.
    p_reset_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> code == SIZE_W'(RST_CODE));

endmodule

// File: rtl/mr_prog_dec.sv
// Module: decodes an instruction fetch against the internal-ROM limit.
// Assumes: the size code selects a power-of-two limit in units of UNIT bytes;
// code 0 means no internal ROM and codes above MAX_CODE clamp to the largest.
module mr_prog_dec #(
    parameter int ADDR_W   = 16,
    parameter int SIZE_W   = 3,
    parameter int UNIT     = 1024,
    parameter int MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] code,
    input  logic              int_en,
    output logic              rom_hit,
    output logic              ext_hit
);

    localparam int LIM_W  = ADDR_W + 1;
    localparam int NCODES = 1 << SIZE_W;

    logic [LIM_W-1:0] lim_tab [NCODES];
    logic [LIM_W-1:0] limit;
    logic             below;

    // Build the limit table, one entry per size code.
    for (genvar c = 0; c < NCODES; c++) begin : g_lim
        if (c == 0) begin : g_zero
            assign lim_tab[c] = '0;
        end else if (c <= MAX_CODE) begin : g_pow
            localparam longint unsigned LIM = longint'(UNIT) << (c - 1);
            assign lim_tab[c] = LIM_W'(LIM);
        end else begin : g_clamp
            localparam longint unsigned LIM = longint'(UNIT) << (MAX_CODE - 1);
            assign lim_tab[c] = LIM_W'(LIM);
        end
    end

    // Compare the fetch address with the live limit and route it.
    always_comb begin
        limit   = lim_tab[code];
        below   = ({1'b0, addr} < limit);
        rom_hit = valid && int_en && below;
        ext_hit = valid && !(int_en && below);
    end

    // R4: with the pin override low, a fetch never reaches the ROM.
    p_override_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !int_en) |-> (ext_hit && !rom_hit));

    // R3: a ROM hit always lies below the selected limit.
    p_rom_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hit |-> ({1'b0, addr} < lim_tab[code]));

endmodule

// File: rtl/mr_data_dec.sv
// Module: decodes a data-space transfer against the on-chip SRAM window.
// Assumes: the SRAM occupies addresses 0 to SRAM_BYTES-1 when enabled.
module mr_data_dec #(
    parameter int ADDR_W     = 16,
    parameter int SRAM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sram_en,
    output logic              sram_hit,
    output logic              ext_hit
);

    localparam logic [ADDR_W:0] WIN_END = (ADDR_W + 1)'(SRAM_BYTES);

    logic in_win;

    // Route inside the enabled window to SRAM, everything else external.
    always_comb begin
        in_win   = ({1'b0, addr} < WIN_END);
        sram_hit = valid && sram_en && in_win;
        ext_hit  = valid && !(sram_en && in_win);
    end

    // R7: an SRAM hit needs the enable and an address inside the window.
    p_sram_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_hit |-> (sram_en && {1'b0, addr} < WIN_END));

    // R8: an address above the window always goes external.
    p_above_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && {1'b0, addr} >= WIN_END) |-> (ext_hit && !sram_hit));

endmodule

// File: rtl/mem_router.sv
// Module: routes fetches and data transfers to on-chip ROM, on-chip SRAM or
// the external bus, and drives the active-low program-store enable.
// Assumes: one access strobe per cycle at most; the address is registered on
// the strobe and decoded against the live size code, pin override and SRAM
// enable, so results appear one cycle after the strobe.
module mem_router #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 3,
    parameter int ROM_UNIT   = 1024,
    parameter int MAX_CODE   = 5,
    parameter int RST_CODE   = 5,
    parameter int SRAM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              int_prog_en,
    input  logic              sram_en,
    input  logic              size_wr,
    input  logic [SIZE_W-1:0] size_wdata,
    output logic              rom_sel,
    output logic              sram_sel,
    output logic              ext_req,
    output logic              psen_n
);
    import mem_route_pkg::*;

    logic              valid_q;
    acc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_code;
    logic              fetch_v;
    logic              data_v;
    logic              p_rom;
    logic              p_ext;
    logic              d_sram;
    logic              d_ext;

    // Register the access strobe, kind and address for decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= ACC_FETCH;
            addr_q  <= '0;
        end else begin
            valid_q <= acc_valid;
            if (acc_valid) begin
                kind_q <= acc_is_data ? ACC_DATA : ACC_FETCH;
                addr_q <= acc_addr;
            end
        end
    end

    mr_size_reg #(
        .SIZE_W   (SIZE_W),
        .RST_CODE (RST_CODE)
    ) u_size (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (size_wr),
        .wdata (size_wdata),
        .code  (size_code)
    );

    // Split the registered access into fetch and data qualifiers.
    always_comb begin
        fetch_v = valid_q && (kind_q == ACC_FETCH);
        data_v  = valid_q && (kind_q == ACC_DATA);
    end

    mr_prog_dec #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .UNIT     (ROM_UNIT),
        .MAX_CODE (MAX_CODE)
    ) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (fetch_v),
        .addr    (addr_q),
        .code    (size_code),
        .int_en  (int_prog_en),
        .rom_hit (p_rom),
        .ext_hit (p_ext)
    );

    mr_data_dec #(
        .ADDR_W     (ADDR_W),
        .SRAM_BYTES (SRAM_BYTES)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (data_v),
        .addr     (addr_q),
        .sram_en  (sram_en),
        .sram_hit (d_sram),
        .ext_hit  (d_ext)
    );

    // Merge decoder results onto the destination strobes.
    always_comb begin
        rom_sel  = p_rom;
        sram_sel = d_sram;
        ext_req  = p_ext || d_ext;
        psen_n   = !p_ext;
    end

    // R9: every strobe yields exactly one destination in the next cycle.
    p_one_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ($countones({rom_sel, sram_sel, ext_req}) == 1));

    // R9: a cycle without a strobe leaves all destinations quiet.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rom_sel && !sram_sel && !ext_req && psen_n));

    // R6: a data transfer never lowers the program-store enable.
    p_psen_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_data) |=> psen_n);

    // R6: the program-store enable is low only alongside an external request.
    p_psen_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> ext_req);

    // R5: shrinking to no ROM in the fetch's own cycle sends it external.
    p_same_cycle_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && size_wdata == '0 && acc_valid && !acc_is_data && int_prog_en)
        |=> (ext_req && !rom_sel));

endmodule

// File: tb/mem_router_bench.sv
module mem_router_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic        acc_is_data;
    logic [15:0] acc_addr;
    logic        int_prog_en;
    logic        sram_en;
    logic        size_wr;
    logic [2:0]  size_wdata;
    logic        rom_sel;
    logic        sram_sel;
    logic        ext_req;
    logic        psen_n;

    always #2 clk = ~clk;

    mem_router u_mem_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_data (acc_is_data),
        .acc_addr    (acc_addr),
        .int_prog_en (int_prog_en),
        .sram_en     (sram_en),
        .size_wr     (size_wr),
        .size_wdata  (size_wdata),
        .rom_sel     (rom_sel),
        .sram_sel    (sram_sel),
        .ext_req     (ext_req),
        .psen_n      (psen_n)
    );

    typedef struct {
        int          due;
        logic [1:0]  route;
        logic        psen;
        string       tag;
    } exp_t;

    exp_t   sb[$];
    int     cyc = 0;
    int     vectors = 0;
    int     miscompares = 0;
    int     code_m = 5;
    bit     done = 0;

    // Route codes: 0 none, 1 ROM, 2 SRAM, 3 external.
    function automatic int lim_of(int code);
        if (code == 0) return 0;
        if (code <= 5) return 1024 << (code - 1);
        return 16384;
    endfunction

    function automatic logic [1:0] model(bit is_data, int addr);
        if (is_data) return (sram_en && addr < 1024) ? 2'd2 : 2'd3;
        return (int_prog_en && addr < lim_of(code_m)) ? 2'd1 : 2'd3;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs just after each edge against the scoreboard.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            logic [1:0] act;
            exp_t e;
            act = rom_sel ? 2'd1 : sram_sel ? 2'd2 : ext_req ? 2'd3 : 2'd0;
            if (sb.size() > 0 && sb[0].due == cyc) begin
                e = sb.pop_front();
            end else begin
                e.due = cyc; e.route = 2'd0; e.psen = 1'b1; e.tag = "R9 idle";
            end
            vectors++;
            if ($countones({rom_sel, sram_sel, ext_req}) > 1 || act != e.route
                || psen_n != e.psen) begin
                miscompares++;
                $display("FAIL %s: actual route=%0d psen_n=%0b sel=%b expected route=%0d psen_n=%0b",
                         e.tag, act, psen_n, {rom_sel, sram_sel, ext_req}, e.route, e.psen);
            end
        end
    end

    // Driver: strobe one access and queue its expected result.
    task automatic apply(bit is_data, int addr, string tag);
        exp_t e;
        @(negedge clk);
        size_wr     = 1'b0;
        acc_valid   = 1'b1;
        acc_is_data = is_data;
        acc_addr    = 16'(addr);
        e.due   = cyc + 1;
        e.route = model(is_data, addr);
        e.psen  = !(e.route == 2'd3 && !is_data);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic write_and_fetch(int code, int addr, string tag);
        exp_t e;
        @(negedge clk);
        size_wr     = 1'b1;
        size_wdata  = 3'(code);
        code_m      = code;
        acc_valid   = 1'b1;
        acc_is_data = 1'b0;
        acc_addr    = 16'(addr);
        e.due   = cyc + 1;
        e.route = model(1'b0, addr);
        e.psen  = (e.route != 2'd3);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic write_size(int code);
        @(negedge clk);
        acc_valid  = 1'b0;
        size_wr    = 1'b1;
        size_wdata = 3'(code);
        code_m     = code;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 1'b0;
            size_wr   = 1'b0;
        end
    endtask

    task automatic set_cfg(bit ip, bit se);
        @(negedge clk);
        acc_valid   = 1'b0;
        size_wr     = 1'b0;
        int_prog_en = ip;
        sram_en     = se;
    endtask

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_is_data = 1'b0; acc_addr = '0;
        int_prog_en = 1'b1; sram_en = 1'b1; size_wr = 1'b0; size_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held.
        vectors++;
        if (rom_sel || sram_sel || ext_req || !psen_n) begin
            miscompares++;
            $display("FAIL R1 reset: actual sel=%b psen_n=%0b expected sel=000 psen_n=1",
                     {rom_sel, sram_sel, ext_req}, psen_n);
        end
        rst_n = 1'b1;
        idle(2);
        // R1: default 16 kB boundary.
        apply(0, 16'h3FFF, "R1 default last ROM byte");
        apply(0, 16'h4000, "R1 default first external");
        idle(1);
        // R2 / R3: every code at its limit.
        for (int c = 0; c < 8; c++) begin
            write_size(c);
            if (lim_of(c) > 0) apply(0, lim_of(c) - 1, "R2 R3 below limit");
            apply(0, lim_of(c), "R2 R3 at limit");
            apply(0, 16'hFFFF, "R3 top of space");
        end
        // R4: pin override.
        write_size(5);
        set_cfg(0, 1);
        apply(0, 16'h0000, "R4 override low addr");
        apply(0, 16'h2000, "R4 override mid addr");
        apply(1, 16'h0010, "R8 data ignores override");
        set_cfg(1, 1);
        // R5: write and fetch in the same cycle, both directions.
        write_and_fetch(3, 16'h1000, "R5 shrink same cycle");
        apply(0, 16'h0FFF, "R5 later fetch below");
        write_and_fetch(5, 16'h1000, "R5 grow same cycle");
        write_and_fetch(0, 16'h0000, "R5 no ROM same cycle");
        write_size(5);
        // R7 / R8: data window.
        apply(1, 16'h0000, "R7 SRAM low");
        apply(1, 16'h03FF, "R7 SRAM top");
        apply(1, 16'h0400, "R8 above window");
        apply(1, 16'hFFFF, "R8 top data");
        write_size(0);
        apply(1, 16'h0200, "R8 data ignores size code");
        write_size(5);
        set_cfg(1, 0);
        apply(1, 16'h0000, "R8 SRAM disabled");
        apply(0, 16'h0000, "R6 ROM fetch psen high");
        set_cfg(1, 1);
        // R9 / R6: back-to-back mixed traffic.
        for (int i = 0; i < 24; i++) begin
            apply(i % 2, (i * 16'h0BCD) & 16'hFFFF, "R9 R6 mixed");
        end
        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule